// File: doc/BRIEF.md
# Peripheral DMA Request Generator

This block sits beside a peripheral's receive FIFO and chooses which of four request lines to present to a DMA controller. The goal is for a transfer of a programmed word count to drain completely, even when the final part is shorter than one burst. Software programs two values and then strobes start. The first is the burst size, which is also the FIFO threshold. The second is the total transfer length in words.

While at least one whole burst of the transfer is still owed, the block waits for the FIFO to reach the threshold. It then raises a burst request. When the burst that remains is the final one, it raises a last-burst request instead. Once fewer words than a burst remain, it switches to one-word single requests, and the final word is flagged with a last-single request.

Each request is held until the controller pulses clear. After a clear, the block waits one cycle so that the FIFO level can reflect the words removed. It then decides on the next request. After the final clear it returns to idle and pulses done.

Top module: `dma_req_gen`

## Requirements
- R1: While reset is asserted, and after it is released, all four request lines, busy and done are low until a transfer is started.
- R2: A start strobe taken while idle, with a non-zero length and a non-zero burst size, latches both values; busy is high from the following cycle until the transfer completes.
- R3: A start strobe with a zero length or a zero burst size is ignored: busy stays low and no request is raised.
- R4: While the remaining count exceeds the burst size, the burst request is raised only once the FIFO level is at least the burst size.
- R5: When the remaining count equals the burst size, the final burst is requested on the last-burst line, again only once the FIFO level is at least the burst size.
- R6: When the remaining count is below the burst size and above one, a single request is raised only once the FIFO level is at least one.
- R7: When exactly one word remains and the burst size is larger than one, the last-single line is raised, again only once the FIFO level is at least one.
- R8: At most one request line is high in any cycle. A raised request holds unchanged until clear is seen, and no request is high in the cycle after the cycle in which clear is seen.
- R9: A clear of a burst or last-burst request lowers the remaining count by the burst size, and a clear of a single or last-single request lowers it by one. For a length L and burst B, the transfer therefore consists of floor(L/B) bursts followed by L mod B singles, and the very last of these requests uses the matching last line.
- R10: In the cycle after the clear of a last-burst or last-single request, done is high for one cycle and busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe for a new transfer |
| xfer_len_i | input | LEN_W | Transfer length in words, sampled on start |
| burst_sz_i | input | BURST_W | Burst size and FIFO threshold, sampled on start |
| fifo_lvl_i | input | LVL_W | Current FIFO fill level in words |
| dma_clr_i | input | 1 | Clear pulse from the controller: the current request has been served |
| breq_o | output | 1 | Burst request |
| lbreq_o | output | 1 | Last-burst request |
| sreq_o | output | 1 | Single request |
| lsreq_o | output | 1 | Last-single request |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | One-cycle pulse when the transfer has finished |

## Verification
The level checks in the properties assume two things about the environment. The burst size input must hold its programmed value for the whole transfer. The controller must pulse clear only while a request is high, and only for one cycle. The bench drives the burst size once before start and leaves it untouched until done. Its controller model raises clear for exactly one cycle, and only after it has seen a request, sometimes holding it back a few cycles first. The FIFO model only fills between clears and is lowered in the same cycle as the clear, by the number of words served.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_BURST,
    RK_LBURST,
    RK_SINGLE,
    RK_LSINGLE
  } req_kind_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_EVAL,
    ST_WAIT,
    ST_SETTLE
  } gen_state_t;

endpackage

// File: rtl/dma_req_pick.sv
module dma_req_pick
  import dma_req_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int BURST_W = 6,
  parameter int LVL_W   = 6
) (
  input  logic [LEN_W-1:0]   rem_i,
  input  logic [BURST_W-1:0] burst_i,
  input  logic [LVL_W-1:0]   lvl_i,
  output req_kind_t          kind_o
);

  localparam int CMP_W = (LVL_W > BURST_W) ? LVL_W : BURST_W;

  logic [LEN_W-1:0] burst_len;
  logic [CMP_W-1:0] burst_cmp;
  logic [CMP_W-1:0] lvl_cmp;
  logic             whole_left;
  logic             enough_words;

  assign burst_len    = LEN_W'(burst_i);
  assign burst_cmp    = CMP_W'(burst_i);
  assign lvl_cmp      = CMP_W'(lvl_i);
  assign whole_left   = (rem_i >= burst_len);
  assign enough_words = (lvl_cmp >= burst_cmp);

  always_comb begin
    kind_o = RK_NONE;
    if (whole_left) begin
      if (enough_words) begin
        kind_o = (rem_i == burst_len) ? RK_LBURST : RK_BURST;
      end
    end else if ((rem_i != '0) && (lvl_i != '0)) begin
      kind_o = (rem_i == LEN_W'(1)) ? RK_LSINGLE : RK_SINGLE;
    end
  end

endmodule

// File: rtl/dma_req_len_cnt.sv
module dma_req_len_cnt #(
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             dec_en_i,
  input  logic [LEN_W-1:0] dec_amt_i,
  output logic [LEN_W-1:0] rem_o
);

  logic [LEN_W-1:0] rem_d;
  logic [LEN_W-1:0] rem_q;
  logic             rem_en;

  assign rem_en = load_i | dec_en_i;

  always_comb begin
    rem_d = rem_q;
    if (load_i) begin
      rem_d = len_i;
    end else if (dec_en_i) begin
      rem_d = rem_q - dec_amt_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
    end else if (rem_en) begin
      rem_q <= rem_d;
    end
  end

  assign rem_o = rem_q;

endmodule

// File: rtl/dma_req_gen.sv
module dma_req_gen
  import dma_req_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int BURST_W = 6,
  parameter int LVL_W   = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [LEN_W-1:0]   xfer_len_i,
  input  logic [BURST_W-1:0] burst_sz_i,
  input  logic [LVL_W-1:0]   fifo_lvl_i,
  input  logic               dma_clr_i,
  output logic               breq_o,
  output logic               lbreq_o,
  output logic               sreq_o,
  output logic               lsreq_o,
  output logic               busy_o,
  output logic               done_o
);

  gen_state_t         state_d, state_q;
  req_kind_t          kind_d, kind_q, pick_kind;
  logic [BURST_W-1:0] burst_q;
  logic               burst_en;
  logic               done_d, done_q;
  logic               load;
  logic               dec_en;
  logic [LEN_W-1:0]   dec_amt;
  logic [LEN_W-1:0]   rem;
  logic               served_burst;
  logic               served_last;

  dma_req_len_cnt #(.LEN_W(LEN_W)) len_cnt_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .len_i     (xfer_len_i),
    .dec_en_i  (dec_en),
    .dec_amt_i (dec_amt),
    .rem_o     (rem)
  );

  dma_req_pick #(.LEN_W(LEN_W), .BURST_W(BURST_W), .LVL_W(LVL_W)) pick_i (
    .rem_i   (rem),
    .burst_i (burst_q),
    .lvl_i   (fifo_lvl_i),
    .kind_o  (pick_kind)
  );

  assign served_burst = (kind_q == RK_BURST) || (kind_q == RK_LBURST);
  assign served_last  = (kind_q == RK_LBURST) || (kind_q == RK_LSINGLE);
  assign dec_amt      = served_burst ? LEN_W'(burst_q) : LEN_W'(1);

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    done_d  = 1'b0;
    load    = 1'b0;
    dec_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i && (xfer_len_i != '0) && (burst_sz_i != '0)) begin
          load    = 1'b1;
          state_d = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (pick_kind != RK_NONE) begin
          kind_d  = pick_kind;
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (dma_clr_i) begin
          dec_en = 1'b1;
          kind_d = RK_NONE;
          if (served_last) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_SETTLE;
          end
        end
      end
      ST_SETTLE: state_d = ST_EVAL;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign burst_en = load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      kind_q  <= RK_NONE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      burst_q <= '0;
    end else if (burst_en) begin
      burst_q <= burst_sz_i;
    end
  end

  assign breq_o  = (kind_q == RK_BURST);
  assign lbreq_o = (kind_q == RK_LBURST);
  assign sreq_o  = (kind_q == RK_SINGLE);
  assign lsreq_o = (kind_q == RK_LSINGLE);
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;

endmodule

// File: rtl/dma_req_gen_chk.sv
module dma_req_gen_chk #(
  parameter int LEN_W   = 16,
  parameter int BURST_W = 6,
  parameter int LVL_W   = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic [LEN_W-1:0]   xfer_len_i,
  input logic [BURST_W-1:0] burst_sz_i,
  input logic [LVL_W-1:0]   fifo_lvl_i,
  input logic               dma_clr_i,
  input logic               breq_o,
  input logic               lbreq_o,
  input logic               sreq_o,
  input logic               lsreq_o,
  input logic               busy_o,
  input logic               done_o
);

  localparam int CMP_W = (LVL_W > BURST_W) ? LVL_W : BURST_W;

  logic [3:0]       req_vec;
  logic             any_req;
  logic             any_blk;
  logic             any_one;
  logic [CMP_W-1:0] lvl_cmp;
  logic [CMP_W-1:0] burst_cmp;

  assign req_vec   = {breq_o, lbreq_o, sreq_o, lsreq_o};
  assign any_req   = |req_vec;
  assign any_blk   = breq_o | lbreq_o;
  assign any_one   = sreq_o | lsreq_o;
  assign lvl_cmp   = CMP_W'(fifo_lvl_i);
  assign burst_cmp = CMP_W'(burst_sz_i);

  assert_one_line_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_vec));

  assert_hold_until_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_req && !dma_clr_i) |=> $stable(req_vec));

  assert_gap_after_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_req && dma_clr_i) |=> !any_req);

  assert_start_taken_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && (xfer_len_i != '0) && (burst_sz_i != '0)) |=> busy_o);

  assert_zero_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && ((xfer_len_i == '0) || (burst_sz_i == '0))) |=> (!busy_o && !any_req));

  assert_burst_level_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(any_blk) |-> ($past(lvl_cmp) >= $past(burst_cmp)));

  assert_single_level_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(any_one) |-> ($past(fifo_lvl_i) != '0));

  assert_done_after_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(dma_clr_i) && !busy_o && !any_req));

endmodule

bind dma_req_gen dma_req_gen_chk #(
  .LEN_W(LEN_W), .BURST_W(BURST_W), .LVL_W(LVL_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .xfer_len_i (xfer_len_i),
  .burst_sz_i (burst_sz_i),
  .fifo_lvl_i (fifo_lvl_i),
  .dma_clr_i  (dma_clr_i),
  .breq_o     (breq_o),
  .lbreq_o    (lbreq_o),
  .sreq_o     (sreq_o),
  .lsreq_o    (lsreq_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/dma_req_gen_tb.sv
module dma_req_gen_tb_top;

  localparam int LEN_W   = 16;
  localparam int BURST_W = 6;
  localparam int LVL_W   = 6;

  logic               clk_i = 1'b0;
  logic               rst_ni;
  logic               start_i;
  logic [LEN_W-1:0]   xfer_len_i;
  logic [BURST_W-1:0] burst_sz_i;
  logic [LVL_W-1:0]   fifo_lvl_i;
  logic               dma_clr_i;
  logic               breq_o, lbreq_o, sreq_o, lsreq_o, busy_o, done_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  dma_req_gen #(.LEN_W(LEN_W), .BURST_W(BURST_W), .LVL_W(LVL_W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .xfer_len_i(xfer_len_i),
    .burst_sz_i(burst_sz_i), .fifo_lvl_i(fifo_lvl_i), .dma_clr_i(dma_clr_i),
    .breq_o(breq_o), .lbreq_o(lbreq_o), .sreq_o(sreq_o), .lsreq_o(lsreq_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int req_code();
    return {28'd0, breq_o, lbreq_o, sreq_o, lsreq_o};
  endfunction

  // codes: 8 burst, 4 last-burst, 2 single, 1 last-single
  task automatic run_xfer(input int len, input int bsz);
    int lvl = 0, produced = 0, rem = len, cyc = 0, hold = 0;
    int nb = 0, nlb = 0, ns = 0, nls = 0;
    int exp_code, need, t_full, t_tail;
    bit last_pend = 0, just_clr = 0;
    @(negedge clk_i);
    fifo_lvl_i = '0;
    xfer_len_i = LEN_W'(len);
    burst_sz_i = BURST_W'(bsz);
    start_i    = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(busy_o === 1'b1, "R2 busy after start", int'(busy_o), 1);
    while (cyc < 3000) begin
      @(negedge clk_i);
      cyc++;
      dma_clr_i = 1'b0;
      if (last_pend) begin
        check(done_o === 1'b1 && busy_o === 1'b0, "R10 done and idle", int'({done_o, busy_o}), 2);
        break;
      end
      check($countones(req_code()) <= 1, "R8 one line", req_code(), 0);
      if (just_clr) begin
        check(req_code() == 0, "R8 quiet after clear", req_code(), 0);
        just_clr = 0;
      end else if (req_code() != 0) begin
        if (rem >= bsz) begin
          exp_code = (rem == bsz) ? 4 : 8;
          need = bsz;
        end else begin
          exp_code = (rem == 1) ? 1 : 2;
          need = 1;
        end
        check(req_code() == exp_code,
              (exp_code >= 4) ? "R4/R5 burst kind" : "R6/R7 single kind",
              req_code(), exp_code);
        check(lvl >= need, (need > 1) ? "R4 level reached" : "R6 level reached", lvl, need);
        if (hold < ((len + bsz + rem) % 3)) begin
          hold++;
        end else begin
          hold = 0;
          dma_clr_i = 1'b1;
          just_clr = 1;
          case (req_code())
            8: nb++;
            4: nlb++;
            2: ns++;
            default: nls++;
          endcase
          if (req_code() == 4 || req_code() == 1) last_pend = 1;
          lvl -= need;
          rem -= need;
        end
      end
      if (produced < len && lvl < 40 && (cyc % 2) == 0) begin
        lvl++;
        produced++;
      end
      fifo_lvl_i = LVL_W'(lvl);
    end
    if (!last_pend) check(1'b0, "R10 transfer never finished", cyc, 0);
    dma_clr_i = 1'b0;
    t_full = len / bsz;
    t_tail = len % bsz;
    check(nb  == ((t_tail == 0) ? t_full - 1 : t_full), "R9 burst count", nb, (t_tail == 0) ? t_full - 1 : t_full);
    check(nlb == ((t_tail == 0) ? 1 : 0), "R9 last-burst count", nlb, (t_tail == 0) ? 1 : 0);
    check(ns  == ((t_tail == 0) ? 0 : t_tail - 1), "R9 single count", ns, (t_tail == 0) ? 0 : t_tail - 1);
    check(nls == ((t_tail == 0) ? 0 : 1), "R9 last-single count", nls, (t_tail == 0) ? 0 : 1);
  endtask

  task automatic try_ignored(input int len, input int bsz);
    @(negedge clk_i);
    fifo_lvl_i = LVL_W'(20);
    xfer_len_i = LEN_W'(len);
    burst_sz_i = BURST_W'(bsz);
    start_i    = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (4) begin
      @(negedge clk_i);
      check(busy_o === 1'b0 && req_code() == 0, "R3 start ignored", int'(busy_o) + req_code(), 0);
    end
    fifo_lvl_i = '0;
  endtask

  initial begin
    rst_ni = 1'b0;
    start_i = 1'b0;
    xfer_len_i = '0;
    burst_sz_i = '0;
    fifo_lvl_i = '0;
    dma_clr_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check(req_code() == 0 && busy_o === 1'b0 && done_o === 1'b0, "R1 in reset",
          req_code() + int'(busy_o) + int'(done_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(req_code() == 0 && busy_o === 1'b0 && done_o === 1'b0, "R1 after reset",
          req_code() + int'(busy_o) + int'(done_o), 0);
    try_ignored(0, 4);
    try_ignored(5, 0);
    for (int b = 1; b <= 5; b++) begin
      for (int l = 1; l <= 20; l++) begin
        run_xfer(l, b);
      end
    end
    try_ignored(0, 1);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule